// File: doc/BRIEF.md
# SCSI Information Phase Tracker

This block sits on the initiator side of a parallel SCSI bus after arbitration and selection have finished. It watches the target's three phase lines and turns them into one of six information phases. For each byte the target requests, it runs the REQ/ACK handshake in the direction the phase calls for. It checks odd parity on bytes that come in and generates it on bytes that go out. It pulses an interrupt whenever the target opens a phase that differs from the one used for the previous byte. The host asks for a message-out phase with a one-cycle request. The block then holds the attention line low until the host's final message byte has been acknowledged.

All bus inputs are active-low and pass through a synchronizer of configurable depth before the handshake engine sees them. The phase lines and data are read only at the moment a new REQ is seen. Outbound bytes come from the host through a valid/ready pair. The block takes one byte per REQ and holds ACK off until that byte is on the bus. Inbound bytes are delivered as a one-cycle valid pulse with no back-pressure.

Top module: `scsi_phase_tracker`

## Requirements
- R1: After reset, ack_n and atn_n are high, db_oe, phase_valid, phase_irq, illegal and rx_valid are low.
- R2: When a new REQ is seen, phase takes the code {MSG asserted, C/D asserted, I/O asserted}: 0 data-out, 1 data-in, 2 command, 3 status, 6 message-out, 7 message-in. phase_valid then goes high.
- R3: phase_irq pulses for one cycle when a byte's legal phase code differs from the code of the previous byte, or when it is the first legal byte after reset. It stays low otherwise.
- R4: Codes 4 and 5 (MSG asserted with C/D negated) set illegal. ACK stays high, no byte is delivered, phase and phase_irq are unchanged, and illegal stays set until the next legal byte clears it.
- R5: For a phase with I/O asserted, the data is latched when REQ is seen and delivered on a one-cycle rx_valid pulse. ACK is asserted from that cycle on, held while REQ stays asserted, and released only after REQ is negated.
- R6: rx_par_err is high with rx_valid exactly when the nine bits db_in and dbp_in hold an even number of ones.
- R7: For a phase with I/O negated, ACK is not asserted until the host byte has been taken on tx_valid and tx_ready. Until ACK is released, db_oe is high and db_out/dbp_out carry that byte with odd parity. db_oe falls when ACK is released and is never high in a phase with I/O asserted.
- R8: A pulse on atn_set drives atn_n low. atn_n returns high in the cycle ACK is asserted for a message-out byte taken with tx_last high. A tx_last byte in any other phase leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Target request, active low |
| msg_n | input | 1 | Message phase line, active low |
| cd_n | input | 1 | Control/data phase line, active low |
| io_n | input | 1 | Direction line, low means target to initiator |
| db_in | input | 8 | Bus data as received |
| dbp_in | input | 1 | Bus parity as received |
| ack_n | output | 1 | Initiator acknowledge, active low |
| atn_n | output | 1 | Attention, active low |
| db_out | output | 8 | Outbound data byte |
| dbp_out | output | 1 | Outbound odd parity bit |
| db_oe | output | 1 | Data bus drive enable |
| tx_valid | input | 1 | Host offers an outbound byte |
| tx_data | input | 8 | Outbound byte from host |
| tx_last | input | 1 | Byte is the last of its message-out phase |
| tx_ready | output | 1 | Block takes the offered byte this cycle |
| atn_set | input | 1 | One-cycle request for a message-out phase |
| phase | output | 3 | Decoded phase code of the latest legal byte |
| phase_valid | output | 1 | A legal byte has been seen since reset |
| phase_irq | output | 1 | One-cycle phase-change pulse |
| illegal | output | 1 | Reserved phase code seen |
| rx_data | output | 8 | Latest inbound byte |
| rx_valid | output | 1 | One-cycle inbound byte strobe |
| rx_par_err | output | 1 | Inbound byte failed the odd-parity check |

## Verification
A bus-side target model walks the bus through every legal phase code, both inbound and outbound. It repeats bytes within a phase to separate a phase change from a repeated phase in the interrupt count. Inbound bytes are sent with correct and deliberately wrong parity, so a missing or inverted parity check shows up. Outbound bytes are offered both at once and after a long host delay, to show that ACK waits for the byte and not just for REQ. Both reserved codes are held on the bus under REQ to show that nothing is acknowledged or delivered. The attention line is exercised with a non-final message byte, a final one, and a tx_last byte in the command phase, which tells the right release point from an early or phase-blind one.

// File: rtl/scsi_ph_pkg.sv
package scsi_ph_pkg;

    localparam int BYTE_W = 8;

    // Phase code is {MSG, C/D, I/O} in asserted (active-high) form.
    typedef enum logic [2:0] {
        PH_DATA_OUT = 3'd0,
        PH_DATA_IN  = 3'd1,
        PH_COMMAND  = 3'd2,
        PH_STATUS   = 3'd3,
        PH_RSVD_A   = 3'd4,
        PH_RSVD_B   = 3'd5,
        PH_MSG_OUT  = 3'd6,
        PH_MSG_IN   = 3'd7
    } phase_e;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_TXWAIT,
        HS_SETUP,
        HS_ACK,
        HS_BAD
    } hs_state_e;

    // Bus sample with every control line in asserted-high form.
    typedef struct packed {
        logic              req;
        logic              msg;
        logic              cd;
        logic              io;
        logic [BYTE_W-1:0] data;
        logic              par;
    } bus_s;

    localparam int BUS_W = $bits(bus_s);

    function automatic logic odd_par(input logic [BYTE_W-1:0] d);
        return ~^d;
    endfunction

    function automatic logic par_ok(input logic [BYTE_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

    function automatic logic phase_legal(input logic msg, input logic cd);
        return !(msg && !cd);
    endfunction

endpackage

// File: rtl/scsi_ph_sync.sv
module scsi_ph_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_pipe
            logic [W-1:0] pipe [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign dout = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/scsi_ph_decode.sv
module scsi_ph_decode
    import scsi_ph_pkg::*;
(
    input  logic              msg,
    input  logic              cd,
    input  logic              io,
    input  logic [BYTE_W-1:0] data,
    input  logic              par,
    output phase_e            ph,
    output logic              legal,
    output logic              inbound,
    output logic              par_good
);

    always_comb begin
        ph       = phase_e'({msg, cd, io});
        legal    = phase_legal(msg, cd);
        inbound  = io;
        par_good = par_ok(data, par);
    end

endmodule

// File: rtl/scsi_ph_hs.sv
module scsi_ph_hs
    import scsi_ph_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [BYTE_W-1:0] bus_data,
    input  phase_e            dec_phase,
    input  logic              dec_legal,
    input  logic              dec_inbound,
    input  logic              dec_par_good,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_ready,
    input  logic              atn_set,
    output logic              ack_n,
    output logic              atn_n,
    output logic              db_oe,
    output logic [BYTE_W-1:0] db_out,
    output logic              dbp_out,
    output phase_e            phase,
    output logic              phase_valid,
    output logic              phase_irq,
    output logic              illegal,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err
);

    hs_state_e st;
    logic      last_q;

    assign tx_ready = (st == HS_TXWAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= HS_IDLE;
            ack_n       <= 1'b1;
            atn_n       <= 1'b1;
            db_oe       <= 1'b0;
            db_out      <= '0;
            dbp_out     <= 1'b0;
            phase       <= PH_DATA_OUT;
            phase_valid <= 1'b0;
            phase_irq   <= 1'b0;
            illegal     <= 1'b0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            rx_par_err  <= 1'b0;
            last_q      <= 1'b0;
        end else begin
            phase_irq  <= 1'b0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            if (atn_set) atn_n <= 1'b0;

            case (st)
                HS_IDLE: begin
                    if (req) begin
                        if (!dec_legal) begin
                            illegal <= 1'b1;
                            st      <= HS_BAD;
                        end else begin
                            illegal     <= 1'b0;
                            phase       <= dec_phase;
                            phase_valid <= 1'b1;
                            phase_irq   <= !phase_valid || (dec_phase != phase);
                            if (dec_inbound) begin
                                rx_data    <= bus_data;
                                rx_valid   <= 1'b1;
                                rx_par_err <= !dec_par_good;
                                ack_n      <= 1'b0;
                                st         <= HS_ACK;
                            end else begin
                                st <= HS_TXWAIT;
                            end
                        end
                    end
                end
                HS_TXWAIT: begin
                    if (tx_valid) begin
                        db_out  <= tx_data;
                        dbp_out <= odd_par(tx_data);
                        db_oe   <= 1'b1;
                        last_q  <= tx_last && (phase == PH_MSG_OUT);
                        st      <= HS_SETUP;
                    end
                end
                HS_SETUP: begin
                    ack_n <= 1'b0;
                    if (last_q) atn_n <= 1'b1;
                    st <= HS_ACK;
                end
                HS_ACK: begin
                    if (!req) begin
                        ack_n <= 1'b1;
                        db_oe <= 1'b0;
                        st    <= HS_IDLE;
                    end
                end
                HS_BAD: begin
                    if (!req) st <= HS_IDLE;
                end
                default: st <= HS_IDLE;
            endcase
        end
    end

    AST_ACK_ON_REQ:     assert property (@(posedge clk) disable iff (rst)
                            $fell(ack_n) |-> $past(req)); // R5
    AST_ACK_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
                            $rose(ack_n) |-> !$past(req)); // R5
    AST_IRQ_PULSE:      assert property (@(posedge clk) disable iff (rst)
                            phase_irq |=> !phase_irq); // R3
    AST_NO_DATA_BAD:    assert property (@(posedge clk) disable iff (rst)
                            illegal |-> (!rx_valid && ack_n)); // R4
    AST_PERR_WITH_RX:   assert property (@(posedge clk) disable iff (rst)
                            rx_par_err |-> rx_valid); // R6
    AST_OE_DIRECTION:   assert property (@(posedge clk) disable iff (rst)
                            db_oe |-> !phase[0]); // R7
    AST_OUT_DRIVEN:     assert property (@(posedge clk) disable iff (rst)
                            (!ack_n && !phase[0]) |-> db_oe); // R7
    AST_OUT_PARITY:     assert property (@(posedge clk) disable iff (rst)
                            db_oe |-> par_ok(db_out, dbp_out)); // R7
    AST_ATN_RELEASE:    assert property (@(posedge clk) disable iff (rst)
                            $rose(atn_n) |-> ($fell(ack_n) && phase == PH_MSG_OUT)); // R8

endmodule

// File: rtl/scsi_phase_tracker.sv
module scsi_phase_tracker
    import scsi_ph_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_n,
    input  logic              msg_n,
    input  logic              cd_n,
    input  logic              io_n,
    input  logic [BYTE_W-1:0] db_in,
    input  logic              dbp_in,
    output logic              ack_n,
    output logic              atn_n,
    output logic [BYTE_W-1:0] db_out,
    output logic              dbp_out,
    output logic              db_oe,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_ready,
    input  logic              atn_set,
    output logic [2:0]        phase,
    output logic              phase_valid,
    output logic              phase_irq,
    output logic              illegal,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err
);

    bus_s             bus_raw;
    bus_s             bus_sync;
    logic [BUS_W-1:0] sync_out;
    phase_e           dec_phase;
    phase_e           cur_phase;
    logic             dec_legal;
    logic             dec_inbound;
    logic             dec_par_good;

    always_comb begin
        bus_raw.req  = ~req_n;
        bus_raw.msg  = ~msg_n;
        bus_raw.cd   = ~cd_n;
        bus_raw.io   = ~io_n;
        bus_raw.data = db_in;
        bus_raw.par  = dbp_in;
    end

    scsi_ph_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (bus_raw),
        .dout (sync_out)
    );

    assign bus_sync = bus_s'(sync_out);

    scsi_ph_decode u_dec (
        .msg      (bus_sync.msg),
        .cd       (bus_sync.cd),
        .io       (bus_sync.io),
        .data     (bus_sync.data),
        .par      (bus_sync.par),
        .ph       (dec_phase),
        .legal    (dec_legal),
        .inbound  (dec_inbound),
        .par_good (dec_par_good)
    );

    scsi_ph_hs u_hs (
        .clk          (clk),
        .rst          (rst),
        .req          (bus_sync.req),
        .bus_data     (bus_sync.data),
        .dec_phase    (dec_phase),
        .dec_legal    (dec_legal),
        .dec_inbound  (dec_inbound),
        .dec_par_good (dec_par_good),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .atn_set      (atn_set),
        .ack_n        (ack_n),
        .atn_n        (atn_n),
        .db_oe        (db_oe),
        .db_out       (db_out),
        .dbp_out      (dbp_out),
        .phase        (cur_phase),
        .phase_valid  (phase_valid),
        .phase_irq    (phase_irq),
        .illegal      (illegal),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_par_err   (rx_par_err)
    );

    assign phase = cur_phase;

endmodule

// File: tb/scsi_phase_tracker_tb.sv
`timescale 1ns/1ps
module scsi_phase_tracker_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_n = 1'b1, msg_n = 1'b1, cd_n = 1'b1, io_n = 1'b1;
    logic [7:0] db_in = 8'h00;
    logic       dbp_in = 1'b1;
    logic       ack_n, atn_n, dbp_out, db_oe, tx_ready;
    logic [7:0] db_out, rx_data;
    logic       tx_valid = 1'b0, tx_last = 1'b0, atn_set = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [2:0] phase;
    logic       phase_valid, phase_irq, illegal, rx_valid, rx_par_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int irq_cnt = 0;
    bit done    = 0;
    logic [8:0] rxq [$];

    always #4 clk = ~clk;

    scsi_phase_tracker u_dut (
        .clk(clk), .rst(rst), .req_n(req_n), .msg_n(msg_n), .cd_n(cd_n), .io_n(io_n),
        .db_in(db_in), .dbp_in(dbp_in), .ack_n(ack_n), .atn_n(atn_n), .db_out(db_out),
        .dbp_out(dbp_out), .db_oe(db_oe), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .atn_set(atn_set), .phase(phase),
        .phase_valid(phase_valid), .phase_irq(phase_irq), .illegal(illegal),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural observer: counts interrupt pulses, queues delivered bytes.
    always @(negedge clk) begin
        if (!rst) begin
            if (phase_irq) irq_cnt = irq_cnt + 1;
            if (rx_valid) rxq.push_back({rx_par_err, rx_data});
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_lines(input logic [2:0] code);
        msg_n = ~code[2];
        cd_n  = ~code[1];
        io_n  = ~code[0];
    endtask

    task automatic wait_ack(input logic lvl, output bit ok);
        ok = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ack_n == lvl) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic tgt_in(input logic [2:0] code, input logic [7:0] d, input bit bad,
                          input int exp_irq);
        int irq0, rx0;
        bit ok;
        logic [8:0] got;
        irq0 = irq_cnt;
        rx0  = rxq.size();
        @(negedge clk);
        set_lines(code);
        db_in  = d;
        dbp_in = (~^d) ^ bad;
        @(negedge clk);
        req_n = 1'b0;
        wait_ack(1'b0, ok);
        chk(ok, "R5 ack after inbound REQ", ack_n, 0);
        chk(db_oe == 1'b0, "R7 bus not driven inbound", db_oe, 0);
        @(negedge clk);
        chk(rxq.size() == rx0 + 1, "R5 one byte delivered", rxq.size() - rx0, 1);
        if (rxq.size() > rx0) begin
            got = rxq[rxq.size() - 1];
            chk(got[7:0] == d, "R5 inbound data", got[7:0], d);
            chk(got[8] == bad, "R6 parity flag", got[8], bad);
        end
        chk(phase == code, "R2 phase code", phase, code);
        chk(irq_cnt - irq0 == exp_irq, "R3 irq count", irq_cnt - irq0, exp_irq);
        repeat (4) @(negedge clk);
        chk(ack_n == 1'b0, "R5 ack held while REQ asserted", ack_n, 0);
        req_n = 1'b1;
        wait_ack(1'b1, ok);
        chk(ok, "R5 ack released after REQ negated", ack_n, 1);
    endtask

    task automatic tgt_out(input logic [2:0] code, input logic [7:0] d, input bit last,
                           input int hdly, input int exp_irq, input logic exp_atn);
        int irq0, take_cyc, ack_cyc;
        bit ok;
        irq0 = irq_cnt;
        take_cyc = 0;
        ack_cyc = 0;
        ok = 0;
        @(negedge clk);
        set_lines(code);
        @(negedge clk);
        req_n = 1'b0;
        fork
            begin
                repeat (hdly) @(negedge clk);
                tx_valid = 1'b1;
                tx_data  = d;
                tx_last  = last;
                while (!tx_ready) @(negedge clk);
                @(posedge clk);
                @(negedge clk);
                take_cyc = cyc;
                tx_valid = 1'b0;
                tx_last  = 1'b0;
            end
            begin
                wait_ack(1'b0, ok);
                ack_cyc = cyc;
                chk(db_oe == 1'b1, "R7 bus driven at ack", db_oe, 1);
                chk(db_out == d, "R7 outbound data", db_out, d);
                chk(dbp_out == ~^d, "R7 outbound odd parity", dbp_out, ~^d);
                chk(atn_n == exp_atn, "R8 atn level at ack", atn_n, exp_atn);
            end
        join
        chk(ok, "R7 ack for outbound byte", ack_n, 0);
        chk(ack_cyc > take_cyc, "R7 ack waits for host byte", ack_cyc, take_cyc + 1);
        @(negedge clk);
        chk(phase == code, "R2 phase code", phase, code);
        chk(irq_cnt - irq0 == exp_irq, "R3 irq count", irq_cnt - irq0, exp_irq);
        req_n = 1'b1;
        wait_ack(1'b1, ok);
        chk(ok, "R5 ack released after REQ negated", ack_n, 1);
        chk(db_oe == 1'b0, "R7 driver off after ack", db_oe, 0);
    endtask

    task automatic tgt_bad(input logic [2:0] code, input logic [2:0] cur_ph);
        int irq0, rx0;
        irq0 = irq_cnt;
        rx0  = rxq.size();
        @(negedge clk);
        set_lines(code);
        @(negedge clk);
        req_n = 1'b0;
        repeat (12) @(negedge clk);
        chk(ack_n == 1'b1, "R4 no ack on reserved code", ack_n, 1);
        chk(illegal == 1'b1, "R4 illegal flag set", illegal, 1);
        chk(rxq.size() == rx0, "R4 no byte delivered", rxq.size() - rx0, 0);
        chk(phase == cur_ph, "R4 phase unchanged", phase, cur_ph);
        chk(irq_cnt == irq0, "R4 no irq", irq_cnt - irq0, 0);
        req_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(illegal == 1'b1 && ack_n == 1'b1, "R4 flag held after REQ negated", illegal, 1);
    endtask

    task automatic pulse_atn;
        @(negedge clk);
        atn_set = 1'b1;
        @(negedge clk);
        atn_set = 1'b0;
        @(negedge clk);
        chk(atn_n == 1'b0, "R8 atn asserted on request", atn_n, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ack_n == 1'b1 && atn_n == 1'b1, "R1 ack/atn idle", {ack_n, atn_n}, 3);
        chk(db_oe == 1'b0 && phase_valid == 1'b0, "R1 oe/phase_valid low", {db_oe, phase_valid}, 0);
        chk(phase_irq == 1'b0 && illegal == 1'b0 && rx_valid == 1'b0, "R1 flags low",
            {phase_irq, illegal, rx_valid}, 0);

        // R8 message-out with attention
        pulse_atn();
        tgt_out(3'd6, 8'h80, 1'b0, 0, 1, 1'b0);
        chk(atn_n == 1'b0, "R8 atn held after non-last byte", atn_n, 0);
        tgt_out(3'd6, 8'h01, 1'b1, 3, 0, 1'b1);
        chk(atn_n == 1'b1, "R8 atn released after last byte", atn_n, 1);

        // command phase, tx_last outside message-out keeps attention
        pulse_atn();
        tgt_out(3'd2, 8'h12, 1'b1, 0, 1, 1'b0);
        chk(atn_n == 1'b0, "R8 tx_last in command keeps atn", atn_n, 0);
        tgt_out(3'd2, 8'h00, 1'b0, 0, 0, 1'b0);

        // inbound data with parity variants
        tgt_in(3'd1, 8'h55, 1'b0, 1);
        tgt_in(3'd1, 8'h00, 1'b0, 0);
        tgt_in(3'd1, 8'h37, 1'b1, 0);
        tgt_in(3'd3, 8'h02, 1'b0, 1);
        tgt_in(3'd7, 8'h00, 1'b1, 1);

        // reserved codes
        tgt_bad(3'd4, 3'd7);
        tgt_bad(3'd5, 3'd7);

        // outbound data after a long host delay clears illegal
        tgt_out(3'd0, 8'hA5, 1'b0, 20, 1, 1'b0);
        chk(illegal == 1'b0, "R4 flag cleared by legal byte", illegal, 0);
        tgt_out(3'd0, 8'h3C, 1'b0, 0, 0, 1'b0);
        tgt_in(3'd7, 8'hFF, 1'b0, 1);

        // final message byte releases attention
        tgt_out(3'd6, 8'h06, 1'b1, 2, 1, 1'b1);
        chk(atn_n == 1'b1, "R8 atn released after single last byte", atn_n, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule